// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block takes up to 32 asynchronous interrupt request lines from outside the chip and turns each one into a clean, clocked interrupt toward a parent interrupt controller. Every line has its own sense selection: active-low level, active-high level, falling edge, rising edge or either edge. Each input passes through a two-stage synchronizer. The block compares the synchronized sample with the one from the cycle before to find edges. When the selected condition is seen, the line's bit in a detect-status register is set.

Software reads and writes the block through a single-cycle 32-bit register port with byte offsets. Bit n of every status and mask register belongs to line n. Detect bits are cleared by writing ones. The enable mask has two write ports: one sets bits and one clears them, and writing a zero to either leaves a bit alone. Each line has its own output, which is high while its detect bit and its enable bit are both set.

Top module: `extint_sense_ctrl`

## Requirements
- R1: Every line input passes through two synchronizing flops. A change on a line input that meets a matching sense shows up in the detect status on the third rising clock edge after the change, and not before.
- R2: The sense code for line n lives in bits [5:0] of the word at offset 0x180 + 4·n, and the upper bits read back as zero. The codes are: 0x01 low level, 0x02 high level, 0x04 falling edge, 0x08 rising edge, 0x0C either edge. Any other code, including the reset value 0, never detects anything.
- R3: Writing to offset 0x08 sets the enable bit of every line whose data bit is 1. Lines whose data bit is 0 keep their enable bit.
- R4: Writing to offset 0x04 clears the enable bit of every line whose data bit is 1. Lines whose data bit is 0 keep their enable bit. Reading offset 0x04 returns the enable mask.
- R5: Offset 0x100 reads the detect status. A detected event sets its bit and the bit stays set. Writing 1 to a bit clears it, and writing 0 has no effect. If an event and a clear hit the same bit in the same cycle, the event wins.
- R6: With level sense, the detect bit stays set as long as the level is active, even across a clear. It stays latched after the level goes away, until it is cleared.
- R7: Output irq_o[n] is high exactly when detect bit n and enable bit n are both 1. Offset 0x00 reads back this masked vector.
- R8: After reset, all enable bits, detect bits and sense codes are 0 and every output is low. Offset 0x08 and all unmapped offsets read as 0.
- R9: An event on one line changes only that line's detect bit. Activity on lines whose sense code is 0 sets nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (9) | Byte offset of the register; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_in | input | NUM_LINES (32) | Asynchronous external interrupt inputs |
| irq_o | output | NUM_LINES (32) | One masked interrupt per line toward the parent controller |

## Verification
Directed sequences step one line through a single rising edge, a held high level, an invalid code and mask writes with mixed ones and zeros. These separate the synchronizer latency, the latching of an edge, the stickiness of a level across a clear, and set/clear register behaviour that leaves zero bits alone. Random trials then pick a line, a sense code, a start level, an end level and an enable bit. They also drive random levels on all other lines, whose sense is off. This tells edge codes apart from level codes (an unchanged level still detects, an unchanged edge does not), rising apart from falling, and one line apart from its neighbours.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int SENSE_W = 6;
    localparam int BUS_W   = 32;

    // Register byte offsets (the decode below depends on these)
    localparam int OFF_REQ      = 'h000;
    localparam int OFF_EN_CLR   = 'h004;
    localparam int OFF_EN_SET   = 'h008;
    localparam int OFF_DET      = 'h100;
    localparam int OFF_CFG_BASE = 'h180;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_OFF    = 6'h00,
        SENSE_LVL_LO = 6'h01,
        SENSE_LVL_HI = 6'h02,
        SENSE_FALL   = 6'h04,
        SENSE_RISE   = 6'h08,
        SENSE_BOTH   = 6'h0C
    } sense_e;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;
    logic [STAGES-1:0][WIDTH-1:0] stage_d;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/extint_line_detect.sv
module extint_line_detect
    import extint_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_i,
    input  logic [SENSE_W-1:0] sense_i,
    output logic               event_o
);

    logic prev_q;
    logic prev_d;
    logic rise;
    logic fall;

    assign prev_d = level_i;
    assign rise   = level_i & ~prev_q;
    assign fall   = ~level_i & prev_q;

    always_comb begin
        case (sense_i)
            SENSE_LVL_LO: event_o = ~level_i;
            SENSE_LVL_HI: event_o = level_i;
            SENSE_FALL:   event_o = fall;
            SENSE_RISE:   event_o = rise;
            SENSE_BOTH:   event_o = rise | fall;
            default:      event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 32,   // 1..32
    parameter int ADDR_W    = 9     // must reach the last config word
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] ext_in,
    output logic [NUM_LINES-1:0] irq_o
);

    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] WA_REQ    = WA_W'(OFF_REQ >> 2);
    localparam logic [WA_W-1:0] WA_EN_CLR = WA_W'(OFF_EN_CLR >> 2);
    localparam logic [WA_W-1:0] WA_EN_SET = WA_W'(OFF_EN_SET >> 2);
    localparam logic [WA_W-1:0] WA_DET    = WA_W'(OFF_DET >> 2);
    localparam logic [WA_W-1:0] WA_CFG    = WA_W'(OFF_CFG_BASE >> 2);

    typedef struct packed {
        logic [NUM_LINES-1:0]              en;
        logic [NUM_LINES-1:0]              det;
        logic [NUM_LINES-1:0][SENSE_W-1:0] cfg;
    } state_t;

    state_t state_d, state_q;

    logic [WA_W-1:0]      word_addr;
    logic [WA_W-1:0]      cfg_idx;
    logic                 is_cfg;
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] ev_w;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] det_q;
    logic [NUM_LINES-1:0] wdata_lines;
    logic                 unused_addr_lsb;

    assign word_addr       = bus_addr[ADDR_W-1:2];
    assign cfg_idx         = word_addr - WA_CFG;
    assign is_cfg          = (word_addr >= WA_CFG) && (cfg_idx < WA_W'(NUM_LINES));
    assign wdata_lines     = bus_wdata[NUM_LINES-1:0];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign en_q            = state_q.en;
    assign det_q           = state_q.det;

    extint_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_in),
        .sync_o  (line_sync)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        extint_line_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (line_sync[g]),
            .sense_i (state_q.cfg[g]),
            .event_o (ev_w[g])
        );
    end

    // Next-state logic
    always_comb begin
        logic [NUM_LINES-1:0] clr_mask;
        state_d  = state_q;
        clr_mask = '0;
        if (bus_wr) begin
            if (word_addr == WA_EN_SET) begin
                state_d.en = state_q.en | wdata_lines;
            end
            if (word_addr == WA_EN_CLR) begin
                state_d.en = state_q.en & ~wdata_lines;
            end
            if (word_addr == WA_DET) begin
                clr_mask = wdata_lines;
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (is_cfg && cfg_idx == WA_W'(i)) begin
                    state_d.cfg[i] = bus_wdata[SENSE_W-1:0];
                end
            end
        end
        // a new event wins over a same-cycle clear
        state_d.det = (state_q.det & ~clr_mask) | ev_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.det & state_q.en;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (word_addr == WA_REQ) begin
            bus_rdata[NUM_LINES-1:0] = irq_o;
        end else if (word_addr == WA_EN_CLR) begin
            bus_rdata[NUM_LINES-1:0] = state_q.en;
        end else if (word_addr == WA_DET) begin
            bus_rdata[NUM_LINES-1:0] = state_q.det;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (is_cfg && cfg_idx == WA_W'(i)) begin
                    bus_rdata[SENSE_W-1:0] = state_q.cfg[i];
                end
            end
        end
    end

endmodule

// File: rtl/extint_sense_ctrl_chk.sv
module extint_sense_ctrl_chk
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [NUM_LINES-1:0] irq_o,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] det_q,
    input logic [NUM_LINES-1:0] ev_w
);

    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] WA_EN_CLR = WA_W'(OFF_EN_CLR >> 2);
    localparam logic [WA_W-1:0] WA_EN_SET = WA_W'(OFF_EN_SET >> 2);
    localparam logic [WA_W-1:0] WA_DET    = WA_W'(OFF_DET >> 2);

    logic [NUM_LINES-1:0] wd;
    logic                 wr_set;
    logic                 wr_clr;
    logic                 wr_det;

    assign wd     = bus_wdata[NUM_LINES-1:0];
    assign wr_set = bus_wr && (bus_addr[ADDR_W-1:2] == WA_EN_SET);
    assign wr_clr = bus_wr && (bus_addr[ADDR_W-1:2] == WA_EN_CLR);
    assign wr_det = bus_wr && (bus_addr[ADDR_W-1:2] == WA_DET);

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_q & $past(wd)) == $past(wd))); // R3

    AST_EN_CLR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((irq_o & $past(wd)) == '0)); // R4

    AST_DET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((det_q & ~$past(det_q) & ~$past(ev_w)) == '0)); // R5

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((det_q & $past(ev_w)) == $past(ev_w))); // R6

    AST_DET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_det |=> ((det_q & $past(det_q)) == $past(det_q))); // R5

    AST_IRQ_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irq_o & ~det_q) == '0)); // R7

endmodule

bind extint_sense_ctrl extint_sense_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .det_q     (det_q),
    .ev_w      (ev_w)
);

// File: tb/extint_sense_ctrl_bench.sv
`timescale 1ns/1ps
module extint_sense_ctrl_bench;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] ext_in = '0;
    logic [N-1:0] irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    extint_sense_ctrl u_extint_sense_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    function automatic logic [8:0] cfg_addr(input int line);
        return 9'(12'h180 + 4 * line);
    endfunction

    // expected detect bit after the input goes from a to b, detect cleared while at a
    function automatic logic exp_det(input logic [5:0] sense, input logic a, input logic b);
        case (sense)
            6'h01:   return !a || !b;
            6'h02:   return a || b;
            6'h04:   return a && !b;
            6'h08:   return !a && b;
            6'h0C:   return a != b;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [5:0] senses [5];
        logic [31:0] seed;
        senses = '{6'h01, 6'h02, 6'h04, 6'h08, 6'h0C};
        seed = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd_check("R8 req", 9'h000, 32'h0);
        rd_check("R8 en", 9'h004, 32'h0);
        rd_check("R8 det", 9'h100, 32'h0);
        rd_check("R8 cfg0", 9'h180, 32'h0);
        rd_check("R8 cfg31", 9'h1FC, 32'h0);
        check("R8 irq", irq_o, 32'h0);

        // R3 / R4 mask registers
        wr(9'h008, 32'h0000_00F0);
        rd_check("R3 set", 9'h004, 32'h0000_00F0);
        wr(9'h008, 32'h0000_0003);
        rd_check("R3 zeros keep", 9'h004, 32'h0000_00F3);
        wr(9'h004, 32'h0000_0030);
        rd_check("R4 clear", 9'h004, 32'h0000_00C3);
        rd_check("R8 set reg reads 0", 9'h008, 32'h0);
        wr(9'h004, 32'hFFFF_FFFF);
        rd_check("R4 clear all", 9'h004, 32'h0);

        // R2 config width, R8 unmapped
        wr(cfg_addr(5), 32'hFFFF_FFFF);
        rd_check("R2 cfg width", cfg_addr(5), 32'h0000_003F);
        wr(cfg_addr(5), 32'h0);
        rd_check("R8 unmapped 0x0C", 9'h00C, 32'h0);
        rd_check("R8 unmapped 0x104", 9'h104, 32'h0);

        // R1 latency with rising sense on line 0
        wr(cfg_addr(0), 32'h08);
        ext_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd_check("R1 not yet", 9'h100, 32'h0);
        @(negedge clk);
        rd_check("R1 third edge", 9'h100, 32'h1);
        // R5 write 0 no effect, write 1 clears
        wr(9'h100, 32'h0);
        rd_check("R5 write 0", 9'h100, 32'h1);
        wr(9'h100, 32'h1);
        repeat (3) @(negedge clk);
        rd_check("R5 write 1 clears", 9'h100, 32'h0);

        // R7 masking
        wr(9'h008, 32'h1);
        check("R7 no det no irq", irq_o, 32'h0);
        ext_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd_check("R2 rising ignores fall", 9'h100, 32'h0);
        ext_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 irq high", irq_o, 32'h1);
        rd_check("R7 req reg", 9'h000, 32'h1);
        wr(9'h004, 32'h1);
        check("R7 masked irq", irq_o, 32'h0);
        rd_check("R7 masked req", 9'h000, 32'h0);
        rd_check("R7 det kept", 9'h100, 32'h1);
        wr(cfg_addr(0), 32'h0);
        wr(9'h100, 32'h1);
        ext_in[0] = 1'b0;

        // R6 level high on line 3
        ext_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd_check("R9 sense off", 9'h100, 32'h0);
        wr(cfg_addr(3), 32'h02);
        @(negedge clk);
        rd_check("R6 level seen", 9'h100, 32'h8);
        wr(9'h100, 32'h8);
        rd_check("R6 sticky while active", 9'h100, 32'h8);
        ext_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        rd_check("R6 latched after level", 9'h100, 32'h8);
        wr(9'h100, 32'h8);
        rd_check("R6 cleared", 9'h100, 32'h0);
        wr(cfg_addr(3), 32'h0);

        // R2 invalid code
        wr(cfg_addr(4), 32'h03);
        ext_in[4] = 1'b1;
        repeat (5) @(negedge clk);
        ext_in[4] = 1'b0;
        repeat (5) @(negedge clk);
        rd_check("R2 invalid code", 9'h100, 32'h0);
        wr(cfg_addr(4), 32'h0);

        // R9 / R2 / R7 random trials
        for (int t = 0; t < 60; t++) begin
            int line;
            logic [5:0] s;
            logic a, b, en, e;
            line = int'($urandom % N);
            s    = senses[$urandom % 5];
            a    = 1'($urandom);
            b    = 1'($urandom);
            en   = 1'($urandom);
            ext_in = $urandom;
            ext_in[line] = a;
            repeat (4) @(negedge clk);
            wr(cfg_addr(line), {26'h0, s});
            wr(9'h100, 32'hFFFF_FFFF);
            if (en) wr(9'h008, 32'h1 << line);
            else    wr(9'h004, 32'h1 << line);
            ext_in[line] = b;
            repeat (4) @(negedge clk);
            e = exp_det(s, a, b);
            rd_check("R9 det only this line", 9'h100, 32'(e) << line);
            rd_check("R7 req random", 9'h000, 32'(e & en) << line);
            check("R7 irq random", irq_o, 32'(e & en) << line);
            wr(cfg_addr(line), 32'h0);
            wr(9'h004, 32'hFFFF_FFFF);
            wr(9'h100, 32'hFFFF_FFFF);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule